// File: doc/BRIEF.md
# Sigma-Delta Result Offset and Gain Corrector

This block sits between a decimation filter and the host-side result register of a multi-channel sigma-delta converter. Each raw filter word arrives with a channel number and a valid strobe. The block first subtracts that channel's offset coefficient. It then multiplies the difference by that channel's gain coefficient. Finally it rounds and clamps the product into a 24-bit or a 16-bit output code. The code is straight binary in unipolar mode and offset binary in bipolar mode.

A calibration controller loads the coefficients through a one-word write port. It typically writes the result of a zero-scale conversion as the offset and a computed scale factor as the gain. Each sample takes the coefficients, mode and word length that are current when it is accepted. A write therefore never disturbs a sample that is already in the pipeline. The pipeline is three stages long and accepts one sample every cycle.

Top module: `adc_cal_corr`

## Requirements
- R1: The output is sat(round((raw - offset) * gain / 2^24)). The offset is removed before the gain is applied, and the offset is a signed two's-complement value at the 24-bit word LSB.
- R2: The gain is a 25-bit unsigned fixed-point number with 24 fractional bits. 0x1000000 is unity and 0x0800000 is one half.
- R3: Each channel has its own offset and gain. `in_ch` selects the pair on the cycle a sample is accepted. A write to one channel leaves every other channel's results unchanged.
- R4: With `mode_bipolar`=1 the raw word is two's complement and the output is offset binary. A corrected value of zero gives 0x800000 in 24-bit mode and 0x8000 in 16-bit mode.
- R5: With `mode_bipolar`=0 the raw word is unsigned. The output code equals the corrected value, so with zero offset and unity gain the output equals the input.
- R6: With `mode_short`=1 the result sits in `out_code[15:0]` and `out_code[23:16]` is zero. The value is rounded half-up on the discarded bits: 0x80 below the 16-bit LSB rounds up, 0x7F rounds down, and -0x80 rounds to zero. In 24-bit mode the gain fraction is rounded half-up at the 24-bit LSB.
- R7: Results below code zero clamp to all-zeros. Results above the largest code clamp to all-ones of the selected width (0xFFFFFF or 0x00FFFF).
- R8: A sample accepted on a rising edge with `in_valid`=1 produces `out_valid`=1 after the second following edge. Back-to-back samples produce back-to-back results in order, exactly one per sample.
- R9: `cw_kind` 0 writes `cw_data[23:0]` as the offset and 1 writes `cw_data[24:0]` as the gain of channel `cw_ch`. A write takes effect for samples accepted on later edges. A sample accepted on the same edge as the write uses the old value.
- R10: Reset clears `out_valid`, discards samples in flight, sets every offset to zero and sets every gain to unity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Raw sample strobe |
| in_ch | input | 2 | Channel of the raw sample |
| in_word | input | 24 | Raw filter word |
| mode_bipolar | input | 1 | 1: two's-complement input, offset-binary output |
| mode_short | input | 1 | 1: 16-bit output word |
| cw_en | input | 1 | Coefficient write strobe |
| cw_kind | input | 1 | 0 offset, 1 gain |
| cw_ch | input | 2 | Channel written |
| cw_data | input | 25 | Coefficient value |
| out_valid | output | 1 | Corrected code strobe |
| out_code | output | 24 | Corrected, rounded, clamped code |

## Verification
A corrupted coefficient register shows up only on samples of its own channel. It appears as a constant code shift (offset) or a proportional error (gain), on the third edge after such a sample enters. A lost or duplicated pipeline valid appears at once as a missing or extra `out_valid` pulse, which breaks the one-result-per-sample order. Channel-separated results show wrong selection or a wrong write target. A rounding error shows up at exact half-LSB inputs, and a wrong order of offset and gain shows up under a non-unity gain.

// File: rtl/adc_corr_pkg.sv
package adc_corr_pkg;

    localparam int RAW_W     = 24;
    localparam int SHORT_W   = 16;
    localparam int GAIN_FRAC = 24;
    localparam int GAIN_W    = GAIN_FRAC + 1;
    localparam int KEEP_FRAC = 6;
    localparam int DIFF_W    = RAW_W + 2;
    localparam int PROD_W    = DIFF_W + GAIN_W + 1;
    localparam int INT_W     = RAW_W + KEEP_FRAC + 3;
    localparam int DROP      = GAIN_FRAC - KEEP_FRAC;
    localparam int NCH_DEF   = 4;

    localparam logic [GAIN_W-1:0] GAIN_UNITY = {1'b1, {GAIN_FRAC{1'b0}}};

    typedef enum logic {
        COEF_OFFSET = 1'b0,
        COEF_GAIN   = 1'b1
    } coef_kind_e;

    typedef struct packed {
        logic                     vld;
        logic                     bip;
        logic                     w16;
        logic signed [DIFF_W-1:0] diff;
        logic [GAIN_W-1:0]        gain;
    } stage1_t;

    typedef struct packed {
        logic                    vld;
        logic                    bip;
        logic                    w16;
        logic signed [INT_W-1:0] val;
    } stage2_t;

    function automatic logic signed [DIFF_W-1:0] widen_raw(
        input logic [RAW_W-1:0] w,
        input logic             bip
    );
        if (bip) return $signed({{(DIFF_W-RAW_W){w[RAW_W-1]}}, w});
        return $signed({{(DIFF_W-RAW_W){1'b0}}, w});
    endfunction

    function automatic logic signed [DIFF_W-1:0] widen_off(input logic [RAW_W-1:0] o);
        return $signed({{(DIFF_W-RAW_W){o[RAW_W-1]}}, o});
    endfunction

endpackage

// File: rtl/coef_bank.sv
module coef_bank
    import adc_corr_pkg::*;
#(
    parameter int NCH  = NCH_DEF,
    parameter int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  coef_kind_e        wr_kind,
    input  logic [CH_W-1:0]   wr_ch,
    input  logic [GAIN_W-1:0] wr_data,
    input  logic [CH_W-1:0]   rd_ch,
    output logic [RAW_W-1:0]  rd_off,
    output logic [GAIN_W-1:0] rd_gain
);

    logic [RAW_W-1:0]  off_q  [NCH];
    logic [GAIN_W-1:0] gain_q [NCH];

    always_ff @(posedge clk) begin
        for (int c = 0; c < NCH; c++) begin
            if (rst) begin
                off_q[c]  <= '0;
                gain_q[c] <= GAIN_UNITY;
            end else if (wr_en && (wr_ch == CH_W'(c))) begin
                if (wr_kind == COEF_GAIN) gain_q[c] <= wr_data;
                else                      off_q[c]  <= wr_data[RAW_W-1:0];
            end
        end
    end

    assign rd_off  = off_q[rd_ch];
    assign rd_gain = gain_q[rd_ch];

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        // R10: coefficients leave reset at zero offset and unity gain
        a_r10_reset_coefs: assert property (@(posedge clk) disable iff (rst)
            $past(rst) |-> (gain_q[g] == GAIN_UNITY && off_q[g] == '0));
        // R9: a gain write lands in the addressed channel on the next edge
        a_r9_gain_write: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wr_kind == COEF_GAIN && wr_ch == CH_W'(g))
            |=> gain_q[g] == $past(wr_data));
    end

endmodule

// File: rtl/corr_stage.sv
module corr_stage
    import adc_corr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [RAW_W-1:0]  raw,
    input  logic              bip,
    input  logic              w16,
    input  logic [RAW_W-1:0]  off,
    input  logic [GAIN_W-1:0] gain,
    output stage2_t           s2
);

    stage1_t                  s1;
    logic signed [PROD_W-1:0] prod;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= '0;
        end else begin
            s1.vld  <= in_valid;
            s1.bip  <= bip;
            s1.w16  <= w16;
            s1.diff <= widen_raw(raw, bip) - widen_off(off);
            s1.gain <= gain;
        end
    end

    assign prod = $signed(s1.diff) * $signed({1'b0, s1.gain});

    always_ff @(posedge clk) begin
        if (rst) begin
            s2 <= '0;
        end else begin
            s2.vld <= s1.vld;
            s2.bip <= s1.bip;
            s2.w16 <= s1.w16;
            s2.val <= INT_W'(prod >>> DROP);
        end
    end

    // R1: at unity gain the scaled value is the offset-corrected difference
    a_r1_unity_passes_diff: assert property (@(posedge clk) disable iff (rst)
        (s1.vld && s1.gain == GAIN_UNITY)
        |=> s2.val == ($signed(INT_W'($past($signed(s1.diff)))) <<< KEEP_FRAC));

    // R8: the valid moves one stage per edge
    a_r8_stage_valid: assert property (@(posedge clk) disable iff (rst)
        s1.vld |=> s2.vld);

endmodule

// File: rtl/out_fmt.sv
module out_fmt
    import adc_corr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  stage2_t          s2,
    output logic             out_valid,
    output logic [RAW_W-1:0] out_code
);

    localparam int XW     = INT_W + 1;
    localparam int SH_L   = KEEP_FRAC;
    localparam int SH_S   = KEEP_FRAC + RAW_W - SHORT_W;
    localparam logic signed [XW-1:0] HALF_L = XW'(64'd1 << (SH_L - 1));
    localparam logic signed [XW-1:0] HALF_S = XW'(64'd1 << (SH_S - 1));
    localparam logic signed [XW-1:0] MID_L  = XW'(64'd1 << (RAW_W - 1));
    localparam logic signed [XW-1:0] MID_S  = XW'(64'd1 << (SHORT_W - 1));
    localparam logic signed [XW-1:0] MAX_L  = XW'((64'd1 << RAW_W) - 64'd1);
    localparam logic signed [XW-1:0] MAX_S  = XW'((64'd1 << SHORT_W) - 64'd1);

    logic signed [XW-1:0] ext, summed, quo, code_s, top_code;
    logic [RAW_W-1:0]     code_n;

    always_comb begin
        ext      = $signed({s2.val[INT_W-1], s2.val});
        summed   = ext + (s2.w16 ? HALF_S : HALF_L);
        quo      = s2.w16 ? (summed >>> SH_S) : (summed >>> SH_L);
        code_s   = quo + (s2.bip ? (s2.w16 ? MID_S : MID_L) : '0);
        top_code = s2.w16 ? MAX_S : MAX_L;
        if (code_s < 0)             code_n = '0;
        else if (code_s > top_code) code_n = RAW_W'(top_code);
        else                        code_n = RAW_W'(code_s);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_code  <= '0;
        end else begin
            out_valid <= s2.vld;
            if (s2.vld) out_code <= code_n;
        end
    end

    // R6: a short word never reaches the upper byte
    a_r6_short_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (s2.vld && s2.w16) |=> out_code[RAW_W-1:SHORT_W] == '0);

    // R4: zero in bipolar mode yields the mid-scale code
    a_r4_bipolar_zero: assert property (@(posedge clk) disable iff (rst)
        (s2.vld && s2.bip && s2.val == '0)
        |=> out_code == ($past(s2.w16) ? RAW_W'(MID_S) : RAW_W'(MID_L)));

endmodule

// File: rtl/adc_cal_corr.sv
module adc_cal_corr
    import adc_corr_pkg::*;
#(
    parameter int  NCH  = NCH_DEF,
    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [CH_W-1:0]   in_ch,
    input  logic [RAW_W-1:0]  in_word,
    input  logic              mode_bipolar,
    input  logic              mode_short,
    input  logic              cw_en,
    input  logic              cw_kind,
    input  logic [CH_W-1:0]   cw_ch,
    input  logic [GAIN_W-1:0] cw_data,
    output logic              out_valid,
    output logic [RAW_W-1:0]  out_code
);

    logic [RAW_W-1:0]  sel_off;
    logic [GAIN_W-1:0] sel_gain;
    stage2_t           s2;

    coef_bank #(.NCH(NCH), .CH_W(CH_W)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cw_en),
        .wr_kind (coef_kind_e'(cw_kind)),
        .wr_ch   (cw_ch),
        .wr_data (cw_data),
        .rd_ch   (in_ch),
        .rd_off  (sel_off),
        .rd_gain (sel_gain)
    );

    corr_stage u_corr (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .raw      (in_word),
        .bip      (mode_bipolar),
        .w16      (mode_short),
        .off      (sel_off),
        .gain     (sel_gain),
        .s2       (s2)
    );

    out_fmt u_fmt (
        .clk       (clk),
        .rst       (rst),
        .s2        (s2),
        .out_valid (out_valid),
        .out_code  (out_code)
    );

    // R8: every accepted sample appears three sampling edges later
    a_r8_latency: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ##3 out_valid);
    // R8: no result without a sample
    a_r8_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !in_valid |-> ##3 !out_valid);

endmodule

// File: tb/adc_cal_corr_bench.sv
`timescale 1ns/1ps
module adc_cal_corr_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [1:0]  in_ch = '0;
    logic [23:0] in_word = '0;
    logic        mode_bipolar = 1'b0;
    logic        mode_short = 1'b0;
    logic        cw_en = 1'b0;
    logic        cw_kind = 1'b0;
    logic [1:0]  cw_ch = '0;
    logic [24:0] cw_data = '0;
    logic        out_valid;
    logic [23:0] out_code;

    int checks = 0;
    int failures = 0;
    int cycle = 0;
    bit done = 0;

    logic [23:0] cur_exp = '0;
    string       cur_tag = "";
    logic [23:0] exp_q[$];
    int          cyc_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    adc_cal_corr u_adc_cal_corr (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ch(in_ch), .in_word(in_word),
        .mode_bipolar(mode_bipolar), .mode_short(mode_short), .cw_en(cw_en),
        .cw_kind(cw_kind), .cw_ch(cw_ch), .cw_data(cw_data),
        .out_valid(out_valid), .out_code(out_code)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    function automatic logic [23:0] model(input logic [23:0] raw, input logic [23:0] off,
                                          input logic [24:0] g, input logic bip, input logic w16);
        longint rv, p, r, mx;
        int sh;
        rv = bip ? longint'($signed(raw)) : longint'({40'd0, raw});
        p  = (rv - longint'($signed(off))) * longint'({39'd0, g});
        sh = w16 ? 32 : 24;
        r  = (p + (64'sd1 <<< (sh - 1))) >>> sh;
        if (bip) r += w16 ? 64'sd32768 : 64'sd8388608;
        mx = w16 ? 64'sd65535 : 64'sd16777215;
        if (r < 0) r = 0;
        if (r > mx) r = mx;
        return r[23:0];
    endfunction

    always @(posedge clk) begin
        cycle <= cycle + 1;
        if (rst) begin
            exp_q.delete(); cyc_q.delete(); tag_q.delete();
        end else if (in_valid) begin
            exp_q.push_back(cur_exp);
            cyc_q.push_back(cycle + 1);
            tag_q.push_back(cur_tag);
        end
    end

    always @(negedge clk) begin
        if (!rst && out_valid && !done) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R8 unexpected out_valid", 1, 0);
            end else begin
                logic [23:0] e;
                int c;
                string t;
                e = exp_q.pop_front();
                c = cyc_q.pop_front();
                t = tag_q.pop_front();
                chk(out_code == e, t, out_code, e);
                chk(cycle - c == 2, "R8 latency", cycle - c, 2);
            end
        end
    end

    task automatic drive(input logic [1:0] ch, input logic [23:0] raw, input logic bip,
                         input logic w16, input logic [23:0] e, input string tag);
        @(negedge clk);
        in_valid = 1'b1; in_ch = ch; in_word = raw;
        mode_bipolar = bip; mode_short = w16; cur_exp = e; cur_tag = tag;
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic send(input logic [1:0] ch, input logic [23:0] raw, input logic bip,
                        input logic w16, input logic [23:0] e, input string tag);
        drive(ch, raw, bip, w16, e, tag);
        idle();
    endtask

    task automatic drain(input string tag);
        repeat (5) @(negedge clk);
        chk(exp_q.size() == 0, {tag, " all results delivered"}, exp_q.size(), 0);
    endtask

    task automatic wr(input logic kind, input logic [1:0] ch, input logic [24:0] d);
        @(negedge clk);
        cw_en = 1'b1; cw_kind = kind; cw_ch = ch; cw_data = d;
        @(negedge clk);
        cw_en = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(out_valid == 1'b0, "R10 reset out_valid", out_valid, 0);
        chk(out_code == 24'h0, "R10 reset out_code", out_code, 0);
    endtask

    task automatic t_defaults();
        send(0, 24'h000000, 1, 0, 24'h800000, "R4 bipolar zero 24");
        send(0, 24'h000123, 1, 0, 24'h800123, "R4 bipolar positive");
        send(0, 24'hFFFFFF, 1, 0, 24'h7FFFFF, "R4 bipolar minus one");
        send(3, 24'hABCDEF, 0, 0, 24'hABCDEF, "R5 unipolar passthrough");
        drain("R10 defaults");
    endtask

    task automatic t_short();
        send(0, 24'h000000, 1, 1, 24'h008000, "R4 bipolar zero 16");
        send(0, 24'h00007F, 1, 1, 24'h008000, "R6 round down");
        send(0, 24'h000080, 1, 1, 24'h008001, "R6 round half up");
        send(0, 24'hFFFF80, 1, 1, 24'h008000, "R6 negative half");
        send(0, 24'h123480, 0, 1, 24'h001235, "R6 unipolar short");
        drain("R6");
    endtask

    task automatic t_offset_gain();
        wr(0, 1, 25'h0000100);
        send(1, 24'h000100, 1, 0, 24'h800000, "R1 offset removed");
        send(0, 24'h000100, 1, 0, 24'h800100, "R3 other channel untouched");
        wr(1, 1, 25'h0800000);
        send(1, 24'h000300, 1, 0, 24'h800100, "R1 R2 offset before half gain");
        send(1, 24'h000301, 1, 0, 24'h800101, "R6 gain fraction rounds half up");
        send(1, 24'h000300, 1, 1, 24'h008001, "R2 short with half gain");
        send(2, 24'h000300, 1, 0, 24'h800300, "R3 gain isolated");
        drain("R1");
    endtask

    task automatic t_saturate();
        wr(1, 0, 25'h1FFFFFF);
        send(0, 24'h600000, 1, 0, 24'hFFFFFF, "R7 bipolar overflow");
        send(0, 24'hA00000, 1, 0, 24'h000000, "R7 bipolar underflow");
        send(0, 24'h900000, 0, 0, 24'hFFFFFF, "R7 unipolar overflow");
        send(0, 24'h600000, 1, 1, 24'h00FFFF, "R7 short overflow");
        wr(0, 2, 25'h0000010);
        send(2, 24'h000008, 0, 0, 24'h000000, "R7 unipolar below zero");
        send(2, 24'h000018, 0, 0, 24'h000008, "R5 unipolar with offset");
        wr(1, 0, 25'h1000000);
        drain("R7");
    endtask

    task automatic t_write_timing();
        @(negedge clk);
        cw_en = 1'b1; cw_kind = 1'b1; cw_ch = 1; cw_data = 25'h1000000;
        in_valid = 1'b1; in_ch = 1; in_word = 24'h000300; mode_bipolar = 1; mode_short = 0;
        cur_exp = 24'h800100; cur_tag = "R9 same-edge write uses old gain";
        @(negedge clk);
        cw_en = 1'b0;
        cur_exp = 24'h800200; cur_tag = "R9 write visible to next sample";
        idle();
        drain("R9");
    endtask

    task automatic t_stream();
        logic [23:0] offs [4];
        logic [24:0] gns  [4];
        offs[0] = 24'h000000; gns[0] = 25'h1000000;
        offs[1] = 24'h000100; gns[1] = 25'h1000000;
        offs[2] = 24'h000010; gns[2] = 25'h1000000;
        offs[3] = 24'hFFFFF0; gns[3] = 25'h0C00000;
        wr(0, 3, 25'h0FFFFF0);
        wr(1, 3, 25'h0C00000);
        for (int i = 0; i < 12; i++) begin
            logic [23:0] raw;
            logic [1:0]  ch;
            raw = 24'(i * 32'h123457) ^ 24'h5A5A5A;
            ch  = 2'(i);
            drive(ch, raw, i[2], i[3], model(raw, offs[ch], gns[ch], i[2], i[3]),
                  "R8 R3 back-to-back stream");
        end
        idle();
        drain("R8 stream");
    endtask

    task automatic t_reset_flight();
        drive(0, 24'h000001, 1, 0, 24'h800001, "R10 flushed");
        drive(0, 24'h000002, 1, 0, 24'h800002, "R10 flushed");
        @(negedge clk);
        in_valid = 1'b0; rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk(out_valid == 1'b0, "R10 in-flight samples discarded", out_valid, 0);
        end
        send(1, 24'h000100, 1, 0, 24'h800100, "R10 offset cleared");
        send(3, 24'h000100, 1, 0, 24'h800100, "R10 gain back to unity");
        drain("R10 after reset");
    endtask

    initial begin
        #2000000;
        if (!done) begin
            done = 1;
            checks++; failures++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_defaults();
        t_short();
        t_offset_gain();
        t_saturate();
        t_write_timing();
        t_stream();
        t_reset_flight();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule